// File: doc/BRIEF.md
# Password-Guarded Clock Control Register Bank

This block is the software-facing register file of a clock controller. A 32-bit word-wide request port carries reads and writes. Every write must carry an unlock key in its most significant byte. A write without the key is dropped silently. A write with the key has that byte cleared before the remaining 24 bits are stored. Reads return the stored words. The exception is word 0, which returns a lock-status vector computed live from the control words of the PLLs.

Each accepted write also produces one-cycle update pulses aimed at the downstream configuration logic:
- A write to a PLL control word pulses that PLL and every output channel it feeds.
- A write to a channel word pulses that channel alone.
- A write to either half of a divider register pair (control word, divide word) pulses that divider.

The PLL, channel and divider datapaths sit outside this block and consume these pulses. The counts of PLLs, channels per PLL and dividers are parameters, and the address map is derived from them.

Top module: `pcr_regbank`

## Requirements
- R1: A write is accepted only when bits 31:24 of the write data equal 8'h5A; any other write changes no register, raises no update pulse and completes with rsp_err low.
- R2: On an accepted write, bits 31:24 are stored as zero and bits 23:0 are stored as written.
- R3: Only word accesses are legal: req_size must be 2'd2 (code 0 = byte, 1 = half, 2 = word) and req_addr[1:0] must be zero. Any other access responds with rsp_err high and rsp_rdata zero, and it changes nothing and pulses nothing.
- R4: Reset holds req_ready, rsp_valid and all update pulses low. Reset loads every PLL word with 32'h0000_0001 (powered down), every channel word and divider control word with zero, and every divide word with 32'h0000_1000.
- R5: Word 0 reads bit p as 1 exactly when bit 0 (power-down) and bit 1 (analog reset) of PLL p's control word are both zero; bits above the PLL count read zero, and writes to word 0 are ignored.
- R6: Address map by word index: 0 lock status, then NUM_PLL PLL words, then channel words (PLL p channel c at p*CH_PER_PLL+c), then one control/divide pair per divider (control at the even offset). Every request completes with rsp_valid one cycle after acceptance, and a read returns the word as it was at acceptance.
- R7: An accepted write to the control word of PLL p pulses pll_upd[p] and chan_upd for all channels of PLL p, and nothing else.
- R8: An accepted write to a channel word pulses only that channel's chan_upd bit.
- R9: An accepted write to either word of divider d pulses only div_upd[d].
- R10: Word indices past the map read zero, and writes to them store nothing and pulse nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data including key byte |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_err | output | 1 | Illegal size or alignment |
| rsp_rdata | output | 32 | Read data |
| pll_upd | output | NUM_PLL | Per-PLL update pulse |
| chan_upd | output | NUM_PLL*CH_PER_PLL | Per-channel update pulse |
| div_upd | output | NUM_DIV | Per-divider update pulse |

## Verification
The bench builds the bank with three PLLs, two channels per PLL, two dividers and a 6-bit address. This yields a 14-word map inside a 16-word space. With that build, the middle PLL's pulse fan-out to its own channel pair is checked against its neighbours, and both halves of each divider pair can be written. Two word indices remain past the map, so the unmapped-read and unmapped-write path (R10) can be exercised. The three lock bits let one PLL be locked while another is held out of lock by power-down and a third by analog reset alone.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
   typedef enum logic [2:0] {
      K_LOCK = 3'd0,
      K_PLL  = 3'd1,
      K_CHAN = 3'd2,
      K_DIV  = 3'd3,
      K_NONE = 3'd4
   } word_kind_e;

   localparam logic [1:0] SIZE_WORD = 2'd2;
   localparam int KEY_LSB   = 24;
   localparam int DATA_BITS = 32;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
   import pcr_pkg::*;
#(
   parameter int NUM_PLL    = 4,
   parameter int CH_PER_PLL = 2,
   parameter int NUM_DIV    = 3,
   parameter int IDX_W      = 5
) (
   input  logic [IDX_W-1:0] word_idx,
   output word_kind_e       kind,
   output logic [IDX_W-1:0] sub
);
   localparam int NUM_CH   = NUM_PLL * CH_PER_PLL;
   localparam int PLL_BASE = 1;
   localparam int CH_BASE  = PLL_BASE + NUM_PLL;
   localparam int DIV_BASE = CH_BASE + NUM_CH;
   localparam int MAP_END  = DIV_BASE + 2 * NUM_DIV;

   logic [IDX_W-1:0] off_div;

   always_comb begin
      kind    = K_NONE;
      sub     = '0;
      off_div = word_idx - IDX_W'(DIV_BASE);
      if (word_idx == '0) begin
         kind = K_LOCK;
      end else if (word_idx < IDX_W'(CH_BASE)) begin
         kind = K_PLL;
         sub  = word_idx - IDX_W'(PLL_BASE);
      end else if (word_idx < IDX_W'(DIV_BASE)) begin
         kind = K_CHAN;
         sub  = word_idx - IDX_W'(CH_BASE);
      end else if (word_idx < IDX_W'(MAP_END)) begin
         kind = K_DIV;
         sub  = off_div >> 1;
      end
   end
endmodule

// File: rtl/pcr_store.sv
module pcr_store #(
   parameter int NUM_PLL    = 4,
   parameter int CH_PER_PLL = 2,
   parameter int NUM_DIV    = 3,
   parameter int IDX_W      = 5,
   parameter logic [31:0] PLL_RST  = 32'h0000_0001,
   parameter logic [31:0] CH_RST   = 32'h0000_0000,
   parameter logic [31:0] DCTL_RST = 32'h0000_0000,
   parameter logic [31:0] DDIV_RST = 32'h0000_1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wr_data,
   output logic [31:0]      words [2**IDX_W]
);
   localparam int SPACE    = 2 ** IDX_W;
   localparam int CH_BASE  = 1 + NUM_PLL;
   localparam int DIV_BASE = CH_BASE + NUM_PLL * CH_PER_PLL;
   localparam int MAP_END  = DIV_BASE + 2 * NUM_DIV;

   for (genvar w = 0; w < SPACE; w++) begin : g_word
      if (w == 0 || w >= MAP_END) begin : g_hole
         assign words[w] = '0;
      end else begin : g_flop
         localparam logic [31:0] RST_VAL =
            (w < CH_BASE)              ? PLL_RST  :
            (w < DIV_BASE)             ? CH_RST   :
            (((w - DIV_BASE) % 2) == 0) ? DCTL_RST : DDIV_RST;
         logic [31:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= RST_VAL;
            else if (wr_en && wr_idx == IDX_W'(w))
               q <= wr_data;
         end
         assign words[w] = q;
      end
   end

   assert_wr_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_data[31:24] == 8'h00);

   assert_wr_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> words[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/pcr_lockmap.sv
module pcr_lockmap #(
   parameter int NUM_PLL  = 4,
   parameter int PD_BIT   = 0,
   parameter int ARST_BIT = 1
) (
   input  logic [31:0] pll_ctrl [NUM_PLL],
   output logic [31:0] lock_word
);
   for (genvar p = 0; p < 32; p++) begin : g_bit
      if (p < NUM_PLL) begin : g_pll
         assign lock_word[p] = !pll_ctrl[p][PD_BIT] && !pll_ctrl[p][ARST_BIT];
      end else begin : g_pad
         assign lock_word[p] = 1'b0;
      end
   end
endmodule

// File: rtl/pcr_regbank.sv
module pcr_regbank
   import pcr_pkg::*;
#(
   parameter int NUM_PLL    = 4,
   parameter int CH_PER_PLL = 2,
   parameter int NUM_DIV    = 3,
   parameter int ADDR_W     = 7,
   parameter logic [7:0]  KEY      = 8'h5A,
   parameter logic [31:0] PLL_RST  = 32'h0000_0001,
   parameter logic [31:0] CH_RST   = 32'h0000_0000,
   parameter logic [31:0] DCTL_RST = 32'h0000_0000,
   parameter logic [31:0] DDIV_RST = 32'h0000_1000
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   output logic                           req_ready,
   input  logic                           req_write,
   input  logic [1:0]                     req_size,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic [31:0]                    req_wdata,
   output logic                           rsp_valid,
   output logic                           rsp_err,
   output logic [31:0]                    rsp_rdata,
   output logic [NUM_PLL-1:0]             pll_upd,
   output logic [NUM_PLL*CH_PER_PLL-1:0]  chan_upd,
   output logic [NUM_DIV-1:0]             div_upd
);
   localparam int IDX_W     = ADDR_W - 2;
   localparam int NUM_CH    = NUM_PLL * CH_PER_PLL;
   localparam int NUM_WORDS = 1 + NUM_PLL + NUM_CH + 2 * NUM_DIV;

   initial begin
      assert (NUM_PLL >= 1 && NUM_PLL <= 32) else $error("NUM_PLL out of range");
      assert (CH_PER_PLL >= 1 && NUM_DIV >= 1) else $error("empty channel or divider set");
      assert (NUM_WORDS <= (1 << IDX_W)) else $error("map exceeds address space");
   end

   logic             ready_q;
   logic             fire, bad_acc, key_ok, wr_ok;
   logic [IDX_W-1:0] word, sub;
   word_kind_e       kind;
   logic [31:0]      words [2**IDX_W];
   logic [31:0]      pll_ctrl [NUM_PLL];
   logic [31:0]      lock_word, rd_mux, wr_clean;
   logic [NUM_PLL-1:0] pll_nxt;
   logic [NUM_CH-1:0]  chan_nxt;
   logic [NUM_DIV-1:0] div_nxt;

   assign req_ready = ready_q;
   assign fire      = req_valid && ready_q;
   assign word      = req_addr[ADDR_W-1:2];
   assign bad_acc   = (req_size != SIZE_WORD) || (req_addr[1:0] != 2'b00);
   assign key_ok    = req_wdata[DATA_BITS-1:KEY_LSB] == KEY;
   assign wr_ok     = fire && req_write && !bad_acc && key_ok &&
                      (kind == K_PLL || kind == K_CHAN || kind == K_DIV);
   assign wr_clean  = {8'h00, req_wdata[KEY_LSB-1:0]};

   pcr_decode #(.NUM_PLL(NUM_PLL), .CH_PER_PLL(CH_PER_PLL), .NUM_DIV(NUM_DIV),
                .IDX_W(IDX_W)) u_decode (
      .word_idx(word), .kind(kind), .sub(sub));

   pcr_store #(.NUM_PLL(NUM_PLL), .CH_PER_PLL(CH_PER_PLL), .NUM_DIV(NUM_DIV),
               .IDX_W(IDX_W), .PLL_RST(PLL_RST), .CH_RST(CH_RST),
               .DCTL_RST(DCTL_RST), .DDIV_RST(DDIV_RST)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_idx(word),
      .wr_data(wr_clean), .words(words));

   for (genvar p = 0; p < NUM_PLL; p++) begin : g_pllsel
      assign pll_ctrl[p] = words[1 + p];
      assign pll_nxt[p]  = wr_ok && kind == K_PLL && sub == IDX_W'(p);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chsel
      assign chan_nxt[c] = wr_ok &&
         ((kind == K_PLL  && sub == IDX_W'(c / CH_PER_PLL)) ||
          (kind == K_CHAN && sub == IDX_W'(c)));
   end

   for (genvar d = 0; d < NUM_DIV; d++) begin : g_divsel
      assign div_nxt[d] = wr_ok && kind == K_DIV && sub == IDX_W'(d);
   end

   pcr_lockmap #(.NUM_PLL(NUM_PLL), .PD_BIT(0), .ARST_BIT(1)) u_lock (
      .pll_ctrl(pll_ctrl), .lock_word(lock_word));

   always_comb begin
      unique case (kind)
         K_LOCK:  rd_mux = lock_word;
         K_NONE:  rd_mux = '0;
         default: rd_mux = words[word];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
         pll_upd   <= '0;
         chan_upd  <= '0;
         div_upd   <= '0;
      end else begin
         ready_q   <= 1'b1;
         rsp_valid <= fire;
         rsp_err   <= fire && bad_acc;
         rsp_rdata <= (fire && !req_write && !bad_acc) ? rd_mux : '0;
         pll_upd   <= pll_nxt;
         chan_upd  <= chan_nxt;
         div_upd   <= div_nxt;
      end
   end

   assert_keyless_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fire && req_write && !key_ok |=> pll_upd == '0 && chan_upd == '0 && div_upd == '0);

   assert_bad_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire && bad_acc |=> rsp_err && rsp_rdata == '0 &&
                          pll_upd == '0 && chan_upd == '0 && div_upd == '0);

   assert_rsp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> rsp_valid);

   assert_one_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pll_upd));

   assert_chan_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chan_upd) <= CH_PER_PLL);

   assert_one_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(div_upd));

   assert_pulse_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_upd != '0 || chan_upd != '0 || div_upd != '0) |-> rsp_valid && !rsp_err);
endmodule

// File: tb/test_pcr_regbank.sv
module test_pcr_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 3, CPP = 2, ND = 2, AW = 6;

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [5:0]  addr;
      logic [31:0] wd;
      logic [31:0] rd;
      logic        err;
      logic [2:0]  pll;
      logic [5:0]  ch;
      logic [1:0]  dv;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd2, 6'h08, 32'h5A00_0000, 32'h0, 1'b0, 3'b010, 6'b001100, 2'b00}, // R7 PLL1 fan-out
      '{1'b0, 2'd2, 6'h08, 32'h0,         32'h0, 1'b0, 3'b000, 6'b000000, 2'b00}, // R6 readback
      '{1'b0, 2'd2, 6'h00, 32'h0,         32'h2, 1'b0, 3'b000, 6'b000000, 2'b00}, // R5 PLL1 locked
      '{1'b1, 2'd2, 6'h04, 32'hA500_0000, 32'h0, 1'b0, 3'b000, 6'b000000, 2'b00}, // R1 wrong key
      '{1'b0, 2'd2, 6'h04, 32'h0,         32'h1, 1'b0, 3'b000, 6'b000000, 2'b00}, // R1 unchanged
      '{1'b1, 2'd2, 6'h0C, 32'h5A00_0002, 32'h0, 1'b0, 3'b100, 6'b110000, 2'b00}, // R7 PLL2
      '{1'b0, 2'd2, 6'h00, 32'h0,         32'h2, 1'b0, 3'b000, 6'b000000, 2'b00}, // R5 analog reset holds
      '{1'b1, 2'd2, 6'h0C, 32'h5A00_00F0, 32'h0, 1'b0, 3'b100, 6'b110000, 2'b00}, // R7 PLL2 again
      '{1'b0, 2'd2, 6'h00, 32'h0,         32'h6, 1'b0, 3'b000, 6'b000000, 2'b00}, // R5 two locked
      '{1'b1, 2'd2, 6'h14, 32'h5AFF_FFFF, 32'h0, 1'b0, 3'b000, 6'b000010, 2'b00}, // R8 channel 1
      '{1'b0, 2'd2, 6'h14, 32'h0,  32'h00FF_FFFF, 1'b0, 3'b000, 6'b000000, 2'b00}, // R2 key stripped
      '{1'b1, 2'd2, 6'h34, 32'h5A12_3456, 32'h0, 1'b0, 3'b000, 6'b000000, 2'b10}, // R9 div1 divide
      '{1'b1, 2'd2, 6'h30, 32'h5A00_0011, 32'h0, 1'b0, 3'b000, 6'b000000, 2'b10}, // R9 div1 control
      '{1'b1, 2'd2, 6'h28, 32'h5A00_0001, 32'h0, 1'b0, 3'b000, 6'b000000, 2'b01}, // R9 div0 control
      '{1'b0, 2'd2, 6'h34, 32'h0,  32'h0012_3456, 1'b0, 3'b000, 6'b000000, 2'b00}, // R2 readback
      '{1'b1, 2'd1, 6'h04, 32'h5A00_0000, 32'h0, 1'b1, 3'b000, 6'b000000, 2'b00}, // R3 half write
      '{1'b1, 2'd2, 6'h06, 32'h5A00_0000, 32'h0, 1'b1, 3'b000, 6'b000000, 2'b00}, // R3 misaligned
      '{1'b0, 2'd2, 6'h04, 32'h0,         32'h1, 1'b0, 3'b000, 6'b000000, 2'b00}, // R3 no effect
      '{1'b0, 2'd2, 6'h09, 32'h0,         32'h0, 1'b1, 3'b000, 6'b000000, 2'b00}, // R3 bad read
      '{1'b1, 2'd2, 6'h00, 32'h5A00_0000, 32'h0, 1'b0, 3'b000, 6'b000000, 2'b00}, // R5 lock write
      '{1'b0, 2'd2, 6'h00, 32'h0,         32'h6, 1'b0, 3'b000, 6'b000000, 2'b00}, // R5 lock intact
      '{1'b1, 2'd2, 6'h3C, 32'h5A00_FFFF, 32'h0, 1'b0, 3'b000, 6'b000000, 2'b00}, // R10 hole write
      '{1'b0, 2'd2, 6'h3C, 32'h0,         32'h0, 1'b0, 3'b000, 6'b000000, 2'b00}  // R10 hole read
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [1:0] req_size = 2'd2;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic req_ready, rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic [NP-1:0] pll_upd;
   logic [NP*CPP-1:0] chan_upd;
   logic [ND-1:0] div_upd;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcr_regbank #(.NUM_PLL(NP), .CH_PER_PLL(CPP), .NUM_DIV(ND), .ADDR_W(AW)) i_pcr_regbank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .pll_upd(pll_upd), .chan_upd(chan_upd), .div_upd(div_upd));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      access(1'b0, 2'd2, a, 32'h0);
      check(tag, {31'b0, rsp_valid}, 32'h1);
      check(tag, rsp_rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R4 ready in reset", {31'b0, req_ready}, 32'h0);
      check("R4 strobes in reset", {21'b0, pll_upd, chan_upd, div_upd}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_check("R4 PLL0 default", 6'h04, 32'h1);
      rd_check("R4 channel default", 6'h10, 32'h0);
      rd_check("R4 divide default", 6'h2C, 32'h1000);
      rd_check("R5 lock after reset", 6'h00, 32'h0);

      for (int i = 0; i < NV; i++) begin
         access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd);
         check($sformatf("vec%0d R6 rsp_valid", i), {31'b0, rsp_valid}, 32'h1);
         check($sformatf("vec%0d R3 rsp_err", i), {31'b0, rsp_err}, {31'b0, VECS[i].err});
         check($sformatf("vec%0d R7/R8/R9 strobes", i),
               {21'b0, pll_upd, chan_upd, div_upd}, {21'b0, VECS[i].pll, VECS[i].ch, VECS[i].dv});
         if (!VECS[i].wr)
            check($sformatf("vec%0d R6 rdata", i), rsp_rdata, VECS[i].rd);
         @(negedge clk);
         check($sformatf("vec%0d R7 pulse one cycle", i),
               {21'b0, pll_upd, chan_upd, div_upd}, 32'h0);
      end

      // R4: reset in mid-run restores defaults
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R4 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_check("R4 PLL2 restored", 6'h0C, 32'h1);
      rd_check("R4 channel restored", 6'h14, 32'h0);
      rd_check("R4 divide restored", 6'h34, 32'h1000);
      rd_check("R5 lock restored", 6'h00, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule